// File: doc/BRIEF.md
# Seeded one-hot ring counter

This block is a synchronous ring of flip-flops that passes a single logic one from stage to stage on every enabled clock. The last stage feeds the first, so a ring of N stages goes through N states. Each stage output is therefore a pulse train at one Nth of the clock rate. The ring does not start in a valid state by itself. Software or a sequencer seeds it in two steps. First, a clear empties every stage. Then a preset pulse plants a one in the first stage. After that, the enable lets the one circulate.

Two patterns never change under rotation: an empty ring and a full ring. A dead-ring flag reports either of them, so the surrounding logic can reseed the ring. A match output compares the whole ring against a target pattern supplied at a port. It can pick out one chosen state, for example to mark a phase of a multi-phase timing signal.

Top module: `ring_seeded`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released, `ringState` is all zeros and `deadFlag` is 1 until the first clear, preset or rotation changes the ring.
- R2: A cycle with `clearReq` high makes every stage of `ringState` 0 after that clock edge, whatever `presetReq` and `runEn` are.
- R3: A cycle with `presetReq` high and `clearReq` low sets bit 0 (the first stage) of `ringState` to 1 after the edge. All other bits keep their values, and no rotation takes place in that cycle even if `runEn` is high.
- R4: A cycle with `runEn` high and both `clearReq` and `presetReq` low rotates the ring after the edge. Bit i+1 takes the old bit i, and bit 0 takes the old bit N-1.
- R5: A cycle with `runEn`, `clearReq` and `presetReq` all low leaves `ringState` unchanged.
- R6: After clear followed by preset, a ring of N stages returns to the value 1 (only bit 0 set) after exactly N rotations. Each stage is high in exactly one of any N consecutive rotated states, and rotation never changes the number of ones.
- R7: `deadFlag` is 1 exactly when `ringState` is all zeros or all ones, in the same cycle. Both patterns persist under rotation.
- R8: `matchHit` is 1 exactly when `ringState` equals `targetPat`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low; empties the ring |
| clearReq | input | 1 | Synchronous clear of every stage; highest priority |
| presetReq | input | 1 | Plants a one in the first stage; beats rotation |
| runEn | input | 1 | Rotation enable |
| targetPat | input | STAGES | Pattern compared against the ring |
| ringState | output | STAGES | Parallel state of all stages, bit 0 is the first stage |
| deadFlag | output | 1 | High when the ring is all zeros or all ones |
| matchHit | output | 1 | High when the ring equals `targetPat` |

## Verification
The main rotation is tried with three seeds, and each one separates a different fault.
- A single seeded one, followed through a full lap, shows the direction of shift, the wrap from the last stage to the first, and the N-cycle period.
- A two-one pattern built from alternating presets and rotations shows that preset touches only the first stage.
- Further preset and rotate steps lead to an all-ones ring. Together with the empty ring, this exercises both dead patterns and shows that they persist under rotation.

Collision cycles with clear, preset and enable raised together separate the priority order. Stepping through the ring while `targetPat` is held fixed shows that the match output fires on the one state it names and on no other.

// File: rtl/ring_seeded_pkg.sv
package ring_seeded_pkg;

  // Strobes from the control to the datapath: at most one is set per cycle.
  typedef struct packed {
    logic doClear;
    logic doPreset;
    logic doRotate;
  } ringStrobe_t;

  localparam int unsigned MinStages = 2;

endpackage

// File: rtl/ring_seeded_ctrl.sv
module ring_seeded_ctrl
  import ring_seeded_pkg::*;
(
  input  logic        clearReq,
  input  logic        presetReq,
  input  logic        runEn,
  output ringStrobe_t strobe
);

  // Fixed priority: clear, then preset, then rotation.
  always_comb begin
    strobe          = '0;
    strobe.doClear  = clearReq;
    strobe.doPreset = presetReq & ~clearReq;
    strobe.doRotate = runEn & ~clearReq & ~presetReq;
  end

endmodule

// File: rtl/ring_seeded_path.sv
module ring_seeded_path
  import ring_seeded_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  output logic [STAGES-1:0] stageQ
);

  logic [STAGES-1:0] stageD;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned Prev = (s == 0) ? STAGES - 1 : s - 1;
    localparam logic        IsFirst = (s == 0);

    always_comb begin
      if (strobe.doClear)
        stageD[s] = 1'b0;
      else if (strobe.doPreset)
        stageD[s] = IsFirst ? 1'b1 : stageQ[s];
      else if (strobe.doRotate)
        stageD[s] = stageQ[Prev];
      else
        stageD[s] = stageQ[s];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= 1'b0;
      else       stageQ[s] <= stageD[s];
    end
  end

endmodule

// File: rtl/ring_seeded_mon.sv
module ring_seeded_mon #(
  parameter int unsigned STAGES = 4
) (
  input  logic [STAGES-1:0] stageQ,
  input  logic [STAGES-1:0] targetPat,
  output logic              deadFlag,
  output logic              matchHit
);

  logic allZero;
  logic allOne;

  always_comb begin
    allZero  = ~|stageQ;
    allOne   = &stageQ;
    deadFlag = allZero | allOne;
    matchHit = (stageQ == targetPat);
  end

endmodule

// File: rtl/ring_seeded.sv
module ring_seeded
  import ring_seeded_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              presetReq,
  input  logic              runEn,
  input  logic [STAGES-1:0] targetPat,
  output logic [STAGES-1:0] ringState,
  output logic              deadFlag,
  output logic              matchHit
);

  if (STAGES < MinStages) begin : g_bad_size
    $error("ring_seeded needs at least two stages");
  end

  ringStrobe_t strobe;

  ring_seeded_ctrl i_ctrl (
    .clearReq (clearReq),
    .presetReq(presetReq),
    .runEn    (runEn),
    .strobe   (strobe)
  );

  ring_seeded_path #(.STAGES(STAGES)) i_path (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .stageQ(ringState)
  );

  ring_seeded_mon #(.STAGES(STAGES)) i_mon (
    .stageQ   (ringState),
    .targetPat(targetPat),
    .deadFlag (deadFlag),
    .matchHit (matchHit)
  );

endmodule

// File: rtl/ring_seeded_chk.sv
module ring_seeded_chk #(
  parameter int unsigned STAGES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic              presetReq,
  input logic              runEn,
  input logic [STAGES-1:0] ringState,
  input logic              deadFlag
);

  // R1: an active reset holds the ring empty.
  always_comb begin
    if (!rstN) a_r1_reset_empty: assert (ringState == '0);
  end

  // R2: clear empties the ring.
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (ringState == '0));

  // R3: preset sets only stage 0.
  a_r3_preset_first: assert property (@(posedge clk) disable iff (!rstN)
    (presetReq && !clearReq) |=>
      (ringState[0] && ringState[STAGES-1:1] == $past(ringState[STAGES-1:1])));

  // R4: rotation moves every bit one stage up, with wrap-around.
  a_r4_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !clearReq && !presetReq) |=>
      (ringState == {$past(ringState[STAGES-2:0]), $past(ringState[STAGES-1])}));

  // R5: nothing requested means no change.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !clearReq && !presetReq) |=> $stable(ringState));

  // R6: rotation keeps the count of ones.
  a_r6_ones_kept: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !clearReq && !presetReq) |=>
      ($countones(ringState) == $countones($past(ringState))));

  // R7: a dead ring stays dead under rotation.
  a_r7_dead_persists: assert property (@(posedge clk) disable iff (!rstN)
    (deadFlag && runEn && !clearReq && !presetReq) |=> deadFlag);

endmodule

bind ring_seeded ring_seeded_chk #(.STAGES(STAGES)) i_chk (.*);

// File: tb/test_ring_seeded.sv
`timescale 1ns/1ps
module test_ring_seeded;

  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clearReq = 1'b0;
  logic         presetReq = 1'b0;
  logic         runEn = 1'b0;
  logic [N-1:0] targetPat = '0;
  logic [N-1:0] ringState;
  logic         deadFlag;
  logic         matchHit;

  int unsigned total = 0;
  int unsigned bad = 0;
  logic [N-1:0] model = '0;

  always #2.5 clk = ~clk;

  ring_seeded #(.STAGES(N)) i_ring_seeded (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .presetReq(presetReq),
    .runEn(runEn), .targetPat(targetPat), .ringState(ringState),
    .deadFlag(deadFlag), .matchHit(matchHit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock with the given requests; the model follows the requirement text.
  task automatic step(input logic c, input logic p, input logic r);
    @(negedge clk);
    clearReq = c; presetReq = p; runEn = r;
    @(posedge clk);
    #1;
    if (c)      model = '0;
    else if (p) model[0] = 1'b1;
    else if (r) model = {model[N-2:0], model[N-1]};
    clearReq = 1'b0; presetReq = 1'b0; runEn = 1'b0;
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " state"}, 32'(ringState), 32'(model));
    chk({"R7 dead"}, 32'(deadFlag), 32'((model == '0) || (model == '1)));
  endtask

  task automatic t_reset();
    chk("R1 state", 32'(ringState), 32'h0);
    chk("R1 dead", 32'(deadFlag), 32'h1);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk("R1 state after release", 32'(ringState), 32'h0);
    chk("R1 dead after release", 32'(deadFlag), 32'h1);
    step(1'b0, 1'b0, 1'b1);
    chk_state("R7 empty ring rotated");
  endtask

  task automatic t_lap();
    int unsigned hits [N];
    step(1'b1, 1'b0, 1'b0);
    chk_state("R2 clear");
    step(1'b0, 1'b1, 1'b0);
    chk("R3 seed", 32'(ringState), 32'h1);
    foreach (hits[k]) hits[k] = 0;
    for (int i = 1; i <= 2 * N; i++) begin
      step(1'b0, 1'b0, 1'b1);
      chk_state("R4 rotate");
      for (int k = 0; k < N; k++) if (ringState[k]) hits[k]++;
      if (i == N) chk("R6 back to seed", 32'(ringState), 32'h1);
    end
    for (int k = 0; k < N; k++) chk("R6 stage duty", hits[k], 2);
  endtask

  task automatic t_hold();
    step(1'b0, 1'b0, 1'b1);
    chk("R4 to 0010", 32'(ringState), 32'h2);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b0);
      chk("R5 hold", 32'(ringState), 32'h2);
    end
  endtask

  task automatic t_priority();
    step(1'b0, 1'b1, 1'b1);
    chk("R3 preset beats rotate", 32'(ringState), 32'h3);
    step(1'b0, 1'b0, 1'b1);
    chk("R4 two ones", 32'(ringState), 32'h6);
    step(1'b1, 1'b1, 1'b1);
    chk("R2 clear beats all", 32'(ringState), 32'h0);
    chk("R7 empty", 32'(deadFlag), 32'h1);
  endtask

  task automatic t_full();
    step(1'b0, 1'b1, 1'b0);
    chk_state("R3 seed again");
    for (int i = 0; i < N - 1; i++) begin
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b0);
      chk_state("R3 fill");
    end
    chk("R7 all ones", 32'(ringState), 32'hF);
    chk("R7 all ones dead", 32'(deadFlag), 32'h1);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 full ring persists", 32'(ringState), 32'hF);
    chk("R7 full ring flag", 32'(deadFlag), 32'h1);
  endtask

  task automatic t_match();
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    targetPat = 4'b0100;
    #1;
    chk("R8 no match", 32'(matchHit), 32'h0);
    for (int i = 0; i < N; i++) begin
      step(1'b0, 1'b0, 1'b1);
      chk("R8 match", 32'(matchHit), 32'(model == 4'b0100));
    end
    @(negedge clk);
    targetPat = ringState;
    #1;
    chk("R8 same-cycle match", 32'(matchHit), 32'h1);
  endtask

  logic finished = 1'b0;

  initial begin
    #1;
    t_reset();
    t_lap();
    t_hold();
    t_priority();
    t_full();
    t_match();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule